// File: doc/BRIEF.md
# Sleep, Wake and Watchdog Controller

This block manages power state for a small processor core. A four-bit control register holds a run bit, a wake-block bit, a software watchdog enable and an option-sense enable. The run bit drives the oscillator enable directly. Software clears the run bit to stop the oscillator and put the core in deep sleep. Setting the run bit again restarts the oscillator, either by a software write or by a hardware wake event.

The wake-capable pins are synchronized and reduced to one combined level by an AND, so any pin pulled low drives the combined level low. A falling edge of that level wakes the core, but only while it sleeps and only if the wake-block bit is clear. Every 0-to-1 transition of the run bit starts a start-up timer. The timer counts pulses of a slow timebase tick and keeps the CPU run enable low until the oscillator has had time to settle.

The watchdog enable output combines a static code-option input with the register's software enable bit. The register's option-sense bit is brought out so that neighbouring logic can sample the option pins.

Top module: `slpwdg_ctrl`

## Requirements
- R1: After reset, reg_rdata reads 0x07: bit0 (wake block) is 1, bit1 (run) is 1, bit2 (watchdog software enable) is 1 and bit3 (option sense) is 0. After reset, osc_en_o is 1 and cpu_run_o is 1.
- R2: When reg_we is high at a clock edge, reg_wdata[3:0] is loaded into control bits 3..0. reg_rdata[7:4] always reads 0, and writes to those bits have no effect.
- R3: osc_en_o equals the run bit (bit1). Writing 0 to bit1 drops osc_en_o and cpu_run_o after that write edge.
- R4: The wake pins pass through SYNC_STAGES flops (default 2) before the AND. The run bit is set when the combined level falls while the run bit is 0 and bit0 is 0. With the defaults, a pin driven low becomes visible on osc_en_o three edges later.
- R5: A wake falling edge has no effect while bit0 is 1. It also has no effect while the run bit is 1. A pin that is already low when sleep begins does not wake the core until it returns high and falls again.
- R6: On every 0-to-1 transition of the run bit, whether from a write or a wake, cpu_run_o is held low. It rises at the edge that samples the OST_TICKS-th tick_i pulse after the transition, whatever code_wdg_opt_i holds. OST_TICKS is round(OST_US/TICK_US), which is 18 by default.
- R7: wdg_en_o is the AND of code_wdg_opt_i, bit2 and the run bit. It is always 0 when code_wdg_opt_i is 0.
- R8: opt_sense_en_o follows bit3.
- R9: A wake event that coincides with a write of 0 to the run bit leaves the run bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register readback |
| wake_pins_i | input | NUM_WAKE | Wake-capable pin levels, asynchronous |
| code_wdg_opt_i | input | 1 | Static code option that permits the watchdog |
| tick_i | input | 1 | Single-cycle pulse of the slow timebase |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_run_o | output | 1 | Instruction execute enable |
| wdg_en_o | output | 1 | Watchdog enable |
| opt_sense_en_o | output | 1 | Option-pin sense enable |

## Verification
Register fields, osc_en_o and opt_sense_en_o change one edge after a write. wdg_en_o also follows code_wdg_opt_i in the same cycle. A wake shows on osc_en_o SYNC_STAGES+1 edges after the pin falls, and cpu_run_o follows at the edge that samples the last required tick. The bench keeps a cycle model that advances at each rising edge and compares all outputs 1 ns after each falling edge, so every result is judged in the cycle it is due. Directed checks count the wake latency in edges and the start-up delay in sampled ticks, and they drive a write of 0 on the very edge where a wake fires.

// File: rtl/slpwdg_pkg.sv
package slpwdg_pkg;

   localparam int CTL_REG_W = 8;
   localparam int CTL_USED_W = 4;

   localparam int BIT_WAKE_BLK = 0;
   localparam int BIT_RUN = 1;
   localparam int BIT_WDG_SW = 2;
   localparam int BIT_OPT_SENSE = 3;

   typedef struct packed {
      logic opt_sense;
      logic wdg_sw;
      logic run;
      logic wake_blk;
   } ctl_t;

   localparam ctl_t CTL_RESET = '{opt_sense: 1'b0, wdg_sw: 1'b1, run: 1'b1, wake_blk: 1'b1};

endpackage

// File: rtl/slpwdg_wake_sync.sv
module slpwdg_wake_sync #(
   parameter int NUM_WAKE = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_WAKE-1:0] pins_i,
   output logic                fall_o
);

   logic [SYNC_STAGES-1:0][NUM_WAKE-1:0] stg_q;
   logic comb_now;
   logic comb_q;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '1;
            else        stg_q[s] <= pins_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '1;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   if (NUM_WAKE == 1) begin : g_single
      assign comb_now = stg_q[SYNC_STAGES-1][0];
   end else begin : g_multi
      assign comb_now = &stg_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) comb_q <= 1'b1;
      else        comb_q <= comb_now;
   end

   assign fall_o = comb_q & ~comb_now;

endmodule

// File: rtl/slpwdg_ctlreg.sv
module slpwdg_ctlreg
   import slpwdg_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we_i,
   input  logic [CTL_USED_W-1:0] wdata_i,
   input  logic                  wake_fall_i,
   output ctl_t                  ctl_o,
   output logic                  run_rise_o
);

   ctl_t ctl_q;
   ctl_t ctl_n;
   logic wake_set;

   assign wake_set = wake_fall_i & ~ctl_q.wake_blk & ~ctl_q.run;

   always_comb begin
      ctl_n = ctl_q;
      if (we_i) ctl_n = ctl_t'(wdata_i);
      if (wake_set) ctl_n.run = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= CTL_RESET;
      else        ctl_q <= ctl_n;
   end

   assign run_rise_o = ~ctl_q.run & ctl_n.run;
   assign ctl_o = ctl_q;

endmodule

// File: rtl/slpwdg_ost.sv
module slpwdg_ost #(
   parameter int TICKS = 18
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic tick_i,
   output logic busy_o
);

   localparam int CNT_W = $clog2(TICKS + 1);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TICKS);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= LOAD_VAL;
      end else if (tick_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/slpwdg_ctrl.sv
module slpwdg_ctrl
   import slpwdg_pkg::*;
#(
   parameter int NUM_WAKE = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TICK_US = 1000,
   parameter int OST_US = 18000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [CTL_REG_W-1:0] reg_wdata,
   output logic [CTL_REG_W-1:0] reg_rdata,
   input  logic [NUM_WAKE-1:0]  wake_pins_i,
   input  logic                 code_wdg_opt_i,
   input  logic                 tick_i,
   output logic                 osc_en_o,
   output logic                 cpu_run_o,
   output logic                 wdg_en_o,
   output logic                 opt_sense_en_o
);

   localparam int OST_TICKS = (OST_US + TICK_US / 2) / TICK_US;

   if (NUM_WAKE < 1) begin : g_bad_wake
      $error("slpwdg_ctrl: NUM_WAKE must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("slpwdg_ctrl: SYNC_STAGES must be at least 1");
   end
   if (TICK_US < 1) begin : g_bad_tick
      $error("slpwdg_ctrl: TICK_US must be positive");
   end
   if (OST_TICKS < 1) begin : g_bad_ost
      $error("slpwdg_ctrl: start-up delay must be at least one tick");
   end

   ctl_t ctl;
   logic wake_fall;
   logic run_rise;
   logic ost_busy;
   logic unused_wdata_hi;

   assign unused_wdata_hi = ^reg_wdata[CTL_REG_W-1:CTL_USED_W];

   slpwdg_wake_sync #(
      .NUM_WAKE   (NUM_WAKE),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .pins_i(wake_pins_i),
      .fall_o(wake_fall)
   );

   slpwdg_ctlreg u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (reg_we),
      .wdata_i    (reg_wdata[CTL_USED_W-1:0]),
      .wake_fall_i(wake_fall),
      .ctl_o      (ctl),
      .run_rise_o (run_rise)
   );

   slpwdg_ost #(
      .TICKS(OST_TICKS)
   ) u_ost (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(run_rise),
      .tick_i(tick_i),
      .busy_o(ost_busy)
   );

   assign reg_rdata = {{(CTL_REG_W - CTL_USED_W){1'b0}}, ctl};
   assign osc_en_o = ctl.run;
   assign cpu_run_o = ctl.run & ~ost_busy;
   assign wdg_en_o = code_wdg_opt_i & ctl.wdg_sw & ctl.run;
   assign opt_sense_en_o = ctl.opt_sense;

endmodule

// File: rtl/slpwdg_ctrl_chk.sv
module slpwdg_ctrl_chk
   import slpwdg_pkg::*;
(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_we,
   input logic [CTL_REG_W-1:0] reg_wdata,
   input logic [CTL_REG_W-1:0] reg_rdata,
   input logic                 code_wdg_opt_i,
   input logic                 tick_i,
   input logic                 osc_en_o,
   input logic                 cpu_run_o,
   input logic                 wdg_en_o,
   input logic                 opt_sense_en_o
);

   assert_hi_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[CTL_REG_W-1:CTL_USED_W] == '0);

   assert_sleep_only_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_en_o) |-> ($past(reg_we) && !$past(reg_wdata[BIT_RUN])));

   assert_blocked_no_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(reg_we) && $past(reg_rdata[BIT_WAKE_BLK])) |-> !$rose(osc_en_o));

   assert_hold_on_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_en_o) |-> !cpu_run_o);

   assert_release_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_run_o) |-> $past(tick_i));

   assert_run_needs_osc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_run_o |-> osc_en_o);

   assert_wdg_option_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !code_wdg_opt_i |-> !wdg_en_o);

   assert_sense_follows_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      opt_sense_en_o == reg_rdata[BIT_OPT_SENSE]);

endmodule

bind slpwdg_ctrl slpwdg_ctrl_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_we        (reg_we),
   .reg_wdata     (reg_wdata),
   .reg_rdata     (reg_rdata),
   .code_wdg_opt_i(code_wdg_opt_i),
   .tick_i        (tick_i),
   .osc_en_o      (osc_en_o),
   .cpu_run_o     (cpu_run_o),
   .wdg_en_o      (wdg_en_o),
   .opt_sense_en_o(opt_sense_en_o)
);

// File: tb/slpwdg_ctrl_tb.sv
module slpwdg_ctrl_tb;

   localparam int NW = 8;
   localparam int SYNC = 2;
   localparam int EXP_OST = 18;
   localparam int TICK_DIV = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [7:0]    reg_wdata = 8'h00;
   logic [7:0]    reg_rdata;
   logic [NW-1:0] pins = '1;
   logic          code_opt = 1'b1;
   logic          tick_i = 1'b0;
   logic          osc_en, cpu_run, wdg_en, opt_en;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   slpwdg_ctrl u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .reg_we        (reg_we),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .wake_pins_i   (pins),
      .code_wdg_opt_i(code_opt),
      .tick_i        (tick_i),
      .osc_en_o      (osc_en),
      .cpu_run_o     (cpu_run),
      .wdg_en_o      (wdg_en),
      .opt_sense_en_o(opt_en)
   );

   always #5 clk = ~clk;

   // slow timebase: one pulse every TICK_DIV clocks
   int tdiv = 0;
   always @(negedge clk) begin
      tdiv = (tdiv + 1) % TICK_DIV;
      tick_i <= (tdiv == 0);
   end

   // behavioural reference model
   bit m_blk = 1, m_run = 1, m_wdg = 1, m_opt = 0;
   int m_ost = 0;
   bit m_prev_low = 0;
   bit m_sync_low[SYNC] = '{default: 0};

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_blk = 1; m_run = 1; m_wdg = 1; m_opt = 0; m_ost = 0;
         m_prev_low = 0;
         foreach (m_sync_low[i]) m_sync_low[i] = 0;
      end else begin
         bit now_low, fell, wake, new_run;
         now_low = m_sync_low[SYNC-1];
         fell = now_low && !m_prev_low;
         wake = fell && !m_blk && !m_run;
         new_run = m_run;
         if (reg_we) begin
            m_blk = reg_wdata[0]; new_run = reg_wdata[1];
            m_wdg = reg_wdata[2]; m_opt = reg_wdata[3];
         end
         if (wake) new_run = 1;
         if (!m_run && new_run) m_ost = EXP_OST;
         else if (tick_i && m_ost > 0) m_ost = m_ost - 1;
         m_run = new_run;
         m_prev_low = now_low;
         for (int i = SYNC - 1; i > 0; i--) m_sync_low[i] = m_sync_low[i-1];
         m_sync_low[0] = (pins != '1);
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         check("R2 rdata", reg_rdata, {4'b0, m_opt, m_wdg, m_run, m_blk});
         check("R3 osc_en", osc_en, m_run);
         check("R6 cpu_run", cpu_run, m_run && (m_ost == 0));
         check("R7 wdg_en", wdg_en, code_opt && m_wdg && m_run);
         check("R8 opt_sense", opt_en, m_opt);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic wake_latency(output int n);
      n = 0;
      while (n < 20) begin
         @(posedge clk); #1; n++;
         if (osc_en) break;
      end
   endtask

   task automatic ost_ticks(output int t);
      t = 0;
      while (t < 100) begin
         @(posedge clk);
         if (tick_i) t++;
         #1;
         if (cpu_run) break;
      end
   endtask

   initial begin
      int n;
      int t;
      cyc(3);
      #1;
      check("R1 reset rdata", reg_rdata, 8'h07);
      check("R1 reset osc", osc_en, 1'b1);
      check("R1 reset run", cpu_run, 1'b1);
      rst_n = 1'b1;
      cyc(2);

      wr(8'h0F); #1;
      check("R8 sense on", opt_en, 1'b1);
      wr(8'hF7); #1;
      check("R2 upper ignored", reg_rdata, 8'h07);

      // sleep with wake enabled, watchdog option on
      wr(8'h0C); #1;
      check("R3 osc stopped", osc_en, 1'b0);
      check("R7 wdg off asleep", wdg_en, 1'b0);
      @(negedge clk); pins[3] = 1'b0;
      wake_latency(n);
      check("R4 wake latency", n, SYNC + 1);
      check("R6 held after wake", cpu_run, 1'b0);
      check("R7 wdg after wake", wdg_en, 1'b1);
      ost_ticks(t);
      check("R6 ticks after wake", t, EXP_OST);
      @(negedge clk); pins = '1;

      // wake blocked
      code_opt = 1'b0;
      wr(8'h0D); cyc(1);
      pins[0] = 1'b0; cyc(10); #1;
      check("R5 blocked", osc_en, 1'b0);
      pins = '1; cyc(4);

      // wake by software write, option off
      wr(8'h06); #1;
      check("R7 option off", wdg_en, 1'b0);
      ost_ticks(t);
      check("R6 ticks after write", t, EXP_OST);

      // falling edge while awake, then sleep with pin still low
      @(negedge clk); pins[5] = 1'b0; cyc(5);
      code_opt = 1'b1;
      wr(8'h04); cyc(10); #1;
      check("R5 stale low", osc_en, 1'b0);
      @(negedge clk); pins = '1; cyc(4);
      @(negedge clk); pins[6] = 1'b0;
      wake_latency(n);
      check("R4 second wake", n, SYNC + 1);
      ost_ticks(t);
      @(negedge clk); pins = '1; cyc(4);

      // wake coincides with a write of 0 to the run bit
      wr(8'h0C); cyc(2);
      pins[1] = 1'b0;            // falls before edge E1
      @(negedge clk);            // after E1
      @(negedge clk);            // after E2
      reg_we = 1'b1; reg_wdata = 8'h0C;
      @(negedge clk);            // after E3, wake fired here
      reg_we = 1'b0;
      #1;
      check("R9 wake wins", osc_en, 1'b1);
      ost_ticks(t);
      pins = '1;
      cyc(10);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule